// File: doc/BRIEF.md
# Checked Shared Bus Resolver

This block resolves a shared bus that several on-chip sources can drive. Every source offers an output-enable bit and a data word. The block picks the bus value from the enabled sources in the same cycle. When no source is enabled, the bus shows a configurable fallback word. Tristate pads are outside this block, so the bus is a plain resolved word.

Alongside the value, the block watches for three kinds of misuse:

- **Contention:** two enabled sources present different words in the same cycle.
- **Float:** nobody drives the bus for too many consecutive cycles.
- **Turnaround:** ownership passes from one source to a different one with no idle cycle in between. This check can be removed by a parameter.

Each kind of misuse gives a one-cycle pulse in the cycle after the clock edge that sampled it. Each pulse is also collected into a sticky bit that only reset clears. The checks run only while the internal reset is released. The external active-low reset asserts asynchronously and is released through two synchronising flops.

Top module: `shared_bus_check`

## Requirements
- R1: With exactly one enable set, `bus_val` equals that source's data word (source i occupies `drv_data[i*DATA_W +: DATA_W]`) in the same cycle, with no clock edge in between.
- R2: With no enable set, `bus_val` equals `IDLE_VALUE` (default 8'hA5).
- R3: If two or more sources are enabled at a sampling edge and their words differ, `err_conflict` is 1 for the one cycle after that edge.
- R4: Several enabled sources that all present the same word cause no contention pulse, and `bus_val` carries that common word.
- R5: During contention, `bus_val` shows the word of the lowest-indexed enabled source.
- R6: When an edge samples a cycle with no enable, and at least `FLOAT_LIMIT` (default 3) idle cycles came just before it, `err_float` is 1 for the following cycle. With the default limit, the fourth idle cycle in a row is the first one flagged.
- R7: Any cycle with an enable set restarts the idle count. The next `FLOAT_LIMIT` idle cycles after it are not flagged.
- R8: With `TURN_CHECK`=1, `err_turn` pulses for one cycle after an edge that samples two things together: the lowest-indexed enabled source differs from the last source that drove, and the previous sampled cycle had an enable set. A repeat by the same source, or a change after an idle cycle, is not flagged.
- R9: `sticky_conflict`, `sticky_float` and `sticky_turn` rise together with their pulse and stay 1 until reset.
- R10: While `rst_n` is low, all pulses and sticky bits are 0 and misuse is not recorded. Reset release reaches the checks after two rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_en | input | N_SRC | Output-enable of each source |
| drv_data | input | N_SRC*DATA_W | Data words, source i at bits i*DATA_W upward |
| bus_val | output | DATA_W | Resolved bus value |
| err_conflict | output | 1 | Contention pulse |
| err_float | output | 1 | Float-timeout pulse |
| err_turn | output | 1 | Missing-turnaround pulse |
| sticky_conflict | output | 1 | Sticky contention status |
| sticky_float | output | 1 | Sticky float status |
| sticky_turn | output | 1 | Sticky turnaround status |

## Verification
The bus value is tried with several enable patterns, and each one separates a different behaviour:

- **A lone enable at each index** exposes wrong slice selection.
- **No enable at all** exposes a missing fallback word.
- **All four enabled with equal words** separates agreement from contention.
- **Two enabled with different words** shows that the lowest index wins.

Runs of idle cycles of different lengths, broken by single driven cycles, pin down the exact float threshold and the restart of the count. Source handovers are tried in three forms: back to back, with an idle gap, and with the same source repeating. Together these separate a real missing turnaround from a harmless change of owner.

// File: rtl/bus_chk_pkg.sv
package bus_chk_pkg;

  typedef struct packed {
    logic conflict;
    logic float_to;
    logic turn;
  } bus_err_t;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/bus_rst_sync.sv
module bus_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/bus_resolve.sv
module bus_resolve #(
  parameter int unsigned N_SRC       = 4,
  parameter int unsigned DATA_W      = 8,
  parameter logic [DATA_W-1:0] IDLE_VALUE = '0,
  localparam int unsigned IDX_W      = bus_chk_pkg::idx_width(N_SRC)
) (
  input  logic [N_SRC-1:0]        drv_en,
  input  logic [N_SRC*DATA_W-1:0] drv_data,
  output logic [DATA_W-1:0]       bus_val,
  output logic                    any_en,
  output logic [IDX_W-1:0]        first_idx,
  output logic                    conflict_now
);

  logic [DATA_W-1:0] word [N_SRC];
  logic [DATA_W-1:0] sel_word;
  logic              found;

  for (genvar g = 0; g < N_SRC; g++) begin : g_split
    assign word[g] = drv_data[g*DATA_W +: DATA_W];
  end

  // lowest-indexed enabled source wins the bus
  always_comb begin
    found     = 1'b0;
    first_idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (drv_en[i] && !found) begin
        found     = 1'b1;
        first_idx = IDX_W'(i);
      end
    end
  end

  assign sel_word = word[first_idx];
  assign any_en   = |drv_en;

  // any other enabled source disagreeing with the winner is contention
  always_comb begin
    conflict_now = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (drv_en[i] && (word[i] != sel_word)) conflict_now = 1'b1;
    end
  end

  assign bus_val = any_en ? sel_word : IDLE_VALUE;

endmodule

// File: rtl/bus_float_mon.sv
module bus_float_mon #(
  parameter int unsigned FLOAT_LIMIT = 3,
  localparam int unsigned CNT_W      = $clog2(FLOAT_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_en,
  output logic float_now
);

  logic [CNT_W-1:0] idle_q;
  logic [CNT_W-1:0] idle_d;
  logic             at_limit;

  assign at_limit = (idle_q >= CNT_W'(FLOAT_LIMIT));

  always_comb begin
    idle_d = idle_q;
    if (any_en)         idle_d = '0;
    else if (!at_limit) idle_d = idle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_q <= '0;
    else        idle_q <= idle_d;
  end

  assign float_now = !any_en && at_limit;

  AST_IDLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q <= CNT_W'(FLOAT_LIMIT)); // R6

  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    any_en |=> (idle_q == '0)); // R7

endmodule

// File: rtl/bus_turn_mon.sv
module bus_turn_mon #(
  parameter int unsigned N_SRC = 4,
  localparam int unsigned IDX_W = bus_chk_pkg::idx_width(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_en,
  input  logic [IDX_W-1:0] first_idx,
  output logic             turn_now
);

  logic [IDX_W-1:0] last_q, last_d;
  logic             prev_act_q, prev_act_d;

  always_comb begin
    last_d     = last_q;
    prev_act_d = any_en;
    if (any_en) last_d = first_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q     <= '0;
      prev_act_q <= 1'b0;
    end else begin
      last_q     <= last_d;
      prev_act_q <= prev_act_d;
    end
  end

  assign turn_now = any_en && prev_act_q && (first_idx != last_q);

  AST_TURN_NEEDS_PREV: assert property (@(posedge clk) disable iff (!rst_n)
    !any_en |=> !turn_now); // R8

endmodule

// File: rtl/shared_bus_check.sv
module shared_bus_check
  import bus_chk_pkg::*;
#(
  parameter int unsigned N_SRC       = 4,
  parameter int unsigned DATA_W      = 8,
  parameter logic [DATA_W-1:0] IDLE_VALUE = 8'hA5,
  parameter int unsigned FLOAT_LIMIT = 3,
  parameter bit          TURN_CHECK  = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        drv_en,
  input  logic [N_SRC*DATA_W-1:0] drv_data,
  output logic [DATA_W-1:0]       bus_val,
  output logic                    err_conflict,
  output logic                    err_float,
  output logic                    err_turn,
  output logic                    sticky_conflict,
  output logic                    sticky_float,
  output logic                    sticky_turn
);

  localparam int unsigned IDX_W = idx_width(N_SRC);

  logic             rst_i_n;
  logic             any_en;
  logic [IDX_W-1:0] first_idx;
  bus_err_t         err_now, pulse_q, pulse_d, sticky_q, sticky_d;

  bus_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  bus_resolve #(
    .N_SRC      (N_SRC),
    .DATA_W     (DATA_W),
    .IDLE_VALUE (IDLE_VALUE)
  ) i_resolve (
    .drv_en       (drv_en),
    .drv_data     (drv_data),
    .bus_val      (bus_val),
    .any_en       (any_en),
    .first_idx    (first_idx),
    .conflict_now (err_now.conflict)
  );

  bus_float_mon #(
    .FLOAT_LIMIT (FLOAT_LIMIT)
  ) i_float (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .any_en    (any_en),
    .float_now (err_now.float_to)
  );

  if (TURN_CHECK) begin : g_turn
    bus_turn_mon #(
      .N_SRC (N_SRC)
    ) i_turn (
      .clk       (clk),
      .rst_n     (rst_i_n),
      .any_en    (any_en),
      .first_idx (first_idx),
      .turn_now  (err_now.turn)
    );
  end else begin : g_no_turn
    assign err_now.turn = 1'b0;
  end

  always_comb begin
    pulse_d  = err_now;
    sticky_d = sticky_q | err_now;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      pulse_q  <= '0;
      sticky_q <= '0;
    end else begin
      pulse_q  <= pulse_d;
      sticky_q <= sticky_d;
    end
  end

  assign err_conflict    = pulse_q.conflict;
  assign err_float       = pulse_q.float_to;
  assign err_turn        = pulse_q.turn;
  assign sticky_conflict = sticky_q.conflict;
  assign sticky_float    = sticky_q.float_to;
  assign sticky_turn     = sticky_q.turn;

  AST_IDLE_SHOWS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(|drv_en) |-> (bus_val == IDLE_VALUE)); // R2

  AST_LONE_NO_CONFLICT: assert property (@(posedge clk) disable iff (!rst_i_n)
    ($countones(drv_en) <= 1) |=> !err_conflict); // R3

  AST_DRIVEN_NO_FLOAT: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|drv_en) |=> !err_float); // R7

  AST_STICKY_CONFLICT_HOLDS: assert property (@(posedge clk) disable iff (!rst_i_n)
    sticky_conflict |=> sticky_conflict); // R9

  AST_STICKY_FLOAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_i_n)
    sticky_float |=> sticky_float); // R9

  AST_PULSE_SETS_STICKY: assert property (@(posedge clk) disable iff (!rst_i_n)
    err_turn |-> sticky_turn); // R9

endmodule

// File: tb/test_shared_bus_check.sv
module test_shared_bus_check;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  drv_en;
  logic [31:0] drv_data;
  logic [7:0]  bus_val;
  logic        err_conflict, err_float, err_turn;
  logic        sticky_conflict, sticky_float, sticky_turn;
  logic [7:0]  bus_seen;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  shared_bus_check i_shared_bus_check (
    .clk             (clk),
    .rst_n           (rst_n),
    .drv_en          (drv_en),
    .drv_data        (drv_data),
    .bus_val         (bus_val),
    .err_conflict    (err_conflict),
    .err_float       (err_float),
    .err_turn        (err_turn),
    .sticky_conflict (sticky_conflict),
    .sticky_float    (sticky_float),
    .sticky_turn     (sticky_turn)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // drive one cycle away from the edge, capture the bus, then cross the edge
  task automatic cyc(input logic [3:0] e, input logic [31:0] d);
    drv_en   = e;
    drv_data = d;
    #2;
    bus_seen = bus_val;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    drv_en = 4'b0000;
    drv_data = '0;
    repeat (2) begin @(posedge clk); #1; end
    rst_n = 1'b1;
    repeat (3) cyc(4'b0001, 32'h0);
  endtask

  task automatic t_reset_state();
    @(posedge clk); #1;
    rst_n = 1'b0;
    drv_en = 4'b0000;
    #2;
    chk("R10 pulses in reset", {err_conflict, err_float, err_turn}, 3'b000);
    chk("R10 sticky in reset", {sticky_conflict, sticky_float, sticky_turn}, 3'b000);
    chk("R2 default in reset", bus_val, 8'hA5);
    // contention while held in reset is not recorded
    cyc(4'b0011, 32'h0000_2211);
    cyc(4'b0011, 32'h0000_2211);
    chk("R10 no conflict in reset", err_conflict, 1'b0);
    chk("R10 no sticky in reset", sticky_conflict, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_single();
    do_reset();
    cyc(4'b0001, 32'h4433_2211);
    chk("R1 src0", bus_seen, 8'h11);
    for (int i = 1; i < 4; i++) begin
      cyc(4'b0000, 32'h0);
      cyc(4'(1 << i), 32'h4433_2211);
      chk($sformatf("R1 src%0d", i), bus_seen, 32'(8'h11 + 8'h11 * i));
      chk("R1 no error", {err_conflict, err_turn}, 2'b00);
    end
  endtask

  task automatic t_default();
    do_reset();
    cyc(4'b0000, 32'hFFFF_FFFF);
    chk("R2 idle default", bus_seen, 8'hA5);
    chk("R6 single idle no float", err_float, 1'b0);
  endtask

  task automatic t_agree();
    do_reset();
    cyc(4'b1111, 32'h3C3C_3C3C);
    chk("R4 common word", bus_seen, 8'h3C);
    chk("R4 no conflict", err_conflict, 1'b0);
    chk("R4 no sticky", sticky_conflict, 1'b0);
  endtask

  task automatic t_conflict();
    do_reset();
    cyc(4'b0000, 32'h0);
    cyc(4'b0110, 32'h0022_1100);
    chk("R5 lowest wins", bus_seen, 8'h11);
    chk("R3 conflict pulse", err_conflict, 1'b1);
    chk("R8 no turn after gap", err_turn, 1'b0);
    cyc(4'b0010, 32'h0022_1100);
    chk("R3 pulse one cycle", err_conflict, 1'b0);
    chk("R9 sticky conflict", sticky_conflict, 1'b1);
    repeat (2) cyc(4'b0010, 32'h0);
    chk("R9 sticky held", sticky_conflict, 1'b1);
    do_reset();
    chk("R9 cleared by reset", sticky_conflict, 1'b0);
  endtask

  task automatic t_float();
    do_reset();
    for (int k = 1; k <= 3; k++) begin
      cyc(4'b0000, 32'h0);
      chk($sformatf("R6 idle %0d no float", k), err_float, 1'b0);
    end
    cyc(4'b0000, 32'h0);
    chk("R6 fourth idle floats", err_float, 1'b1);
    cyc(4'b0000, 32'h0);
    chk("R6 fifth idle floats", err_float, 1'b1);
    cyc(4'b0001, 32'h0);
    chk("R7 driven clears float", err_float, 1'b0);
    chk("R9 sticky float", sticky_float, 1'b1);
    for (int k = 1; k <= 3; k++) begin
      cyc(4'b0000, 32'h0);
      chk($sformatf("R7 restart idle %0d", k), err_float, 1'b0);
    end
  endtask

  task automatic t_turn();
    do_reset();
    cyc(4'b0100, 32'h0077_0000);
    chk("R8 back to back handover", err_turn, 1'b1);
    cyc(4'b0100, 32'h0077_0000);
    chk("R8 same source repeat", err_turn, 1'b0);
    chk("R9 sticky turn", sticky_turn, 1'b1);
    cyc(4'b0000, 32'h0);
    cyc(4'b0010, 32'h0000_5500);
    chk("R8 handover after gap", err_turn, 1'b0);
    cyc(4'b0001, 32'h0000_0066);
    chk("R8 handover 1 to 0", err_turn, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0;
    drv_en = '0;
    drv_data = '0;
    t_reset_state();
    t_single();
    t_default();
    t_agree();
    t_conflict();
    t_float();
    t_turn();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule